// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This unit resolves a single instruction operand. A caller presents a 3-bit mode code, a register index and a constant field together with a one-cycle start pulse. The unit then uses a register-file read port and a memory read port to work out where the operand lives and what its value is. When it has both, it raises done for one cycle. The operand value, the effective address, a flag saying whether the address is meaningful and an error flag are then held stable until the next start.

Six mode codes are recognised. Immediate takes the constant as the value. Register takes the contents of the named register. Absolute treats the constant as the address. Register-indirect uses a register as a pointer. Memory-indirect fetches the pointer from memory at the constant address. Indexed adds the constant to a register. Memory reads use a request/ready handshake: the unit holds the request and the address until ready is seen, so memory may insert any number of wait cycles.

Top module: `opf_unit`

## Requirements
- R1: After reset, busy_o, done_o, err_o, ea_valid_o and mem_req_o are all 0.
- R2: Mode code 0 (immediate) returns operand_o equal to the constant field and ea_valid_o = 0. It performs no memory read, and done_o is seen in the second cycle after the start pulse.
- R3: Mode code 1 (register) returns the contents of the register at reg_idx_i, with ea_valid_o = 0 and no memory read.
- R4: Mode code 2 (absolute) returns ea_o equal to the constant field with ea_valid_o = 1. The operand is the memory word read at that address, using exactly one memory read.
- R5: Mode code 3 (register-indirect) returns ea_o equal to the contents of the named register. The operand is read from memory at ea_o, using one read.
- R6: Mode code 4 (memory-indirect) reads memory at the constant address first and uses that word as ea_o. It then reads the operand at ea_o. Each read waits for mem_ready_i, so with k wait cycles per read, done_o arrives 2 + 2(k+1) cycles after start.
- R7: Mode code 5 (indexed) returns ea_o = (constant + register contents) modulo 2^16 and reads the operand at ea_o.
- R8: Mode codes 6 and 7 raise err_o together with done_o, keep ea_valid_o = 0 and perform no memory read. The next valid operation clears err_o.
- R9: A start pulse that arrives while busy_o is 1 is ignored. The running operation completes with its own result and produces no extra done_o.
- R10: done_o is high for exactly one cycle. While mem_req_o is high and mem_ready_i is low, mem_req_o stays high and mem_addr_o stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; sampled only when idle |
| mode_i | input | 3 | Addressing mode code |
| reg_idx_i | input | 4 | Register index from the instruction |
| const_i | input | 16 | Constant field from the instruction |
| rf_raddr_o | output | 4 | Register-file read index |
| rf_rdata_i | input | 16 | Register-file read data (same cycle) |
| mem_req_o | output | 1 | Memory read request, held until ready |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 16 | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory read completion |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Unknown mode code |
| operand_o | output | 16 | Resolved operand value |
| ea_o | output | 16 | Effective address |
| ea_valid_o | output | 1 | ea_o is meaningful |

## Verification
The bench drives memory-indirect with wait states and checks the order of the two read addresses and the total latency. A unit that skipped the pointer read would return the word at the constant address as the operand. A unit that ignored ready would finish early with stale data. The indexed test chooses a constant and register value whose sum overflows 16 bits; a unit that mishandled the carry would read the wrong word. A second start is sent during a slow memory read, and unknown mode codes are tried. A unit that restarted on the second start, or touched memory on an unknown code, would give a changed result, an extra done pulse or a non-zero read count.

// File: rtl/opf_pkg.sv
package opf_pkg;
    localparam logic [2:0] MODE_IMM  = 3'd0;
    localparam logic [2:0] MODE_REG  = 3'd1;
    localparam logic [2:0] MODE_ABS  = 3'd2;
    localparam logic [2:0] MODE_RIND = 3'd3;
    localparam logic [2:0] MODE_MIND = 3'd4;
    localparam logic [2:0] MODE_IDX  = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_PTR,
        ST_FETCH,
        ST_DONE
    } opf_state_e;
endpackage

// File: rtl/opf_ea_calc.sv
module opf_ea_calc
    import opf_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic [2:0]    mode_i,
    input  logic [AW-1:0] cst_i,
    input  logic [DW-1:0] rf_rdata_i,
    output opf_state_e    next_o,
    output logic [AW-1:0] ea_o,
    output logic          ea_valid_o,
    output logic [DW-1:0] operand_o,
    output logic          operand_load_o,
    output logic          err_o
);
    logic [AW-1:0] reg_as_addr;
    assign reg_as_addr = AW'(rf_rdata_i);

    always_comb begin
        next_o         = ST_DONE;
        ea_o           = '0;
        ea_valid_o     = 1'b0;
        operand_o      = '0;
        operand_load_o = 1'b0;
        err_o          = 1'b0;
        case (mode_i)
            MODE_IMM: begin
                operand_o      = DW'(cst_i);
                operand_load_o = 1'b1;
            end
            MODE_REG: begin
                operand_o      = rf_rdata_i;
                operand_load_o = 1'b1;
            end
            MODE_ABS: begin
                ea_o       = cst_i;
                ea_valid_o = 1'b1;
                next_o     = ST_FETCH;
            end
            MODE_RIND: begin
                ea_o       = reg_as_addr;
                ea_valid_o = 1'b1;
                next_o     = ST_FETCH;
            end
            MODE_MIND: begin
                next_o = ST_PTR;
            end
            MODE_IDX: begin
                ea_o       = cst_i + reg_as_addr;
                ea_valid_o = 1'b1;
                next_o     = ST_FETCH;
            end
            default: begin
                err_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/opf_seq.sv
module opf_seq
    import opf_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 16,
    parameter int RIW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [2:0]     mode_i,
    input  logic [RIW-1:0] reg_idx_i,
    input  logic [AW-1:0]  const_i,
    input  opf_state_e     c_next_i,
    input  logic [AW-1:0]  c_ea_i,
    input  logic           c_ea_valid_i,
    input  logic [DW-1:0]  c_operand_i,
    input  logic           c_operand_load_i,
    input  logic           c_err_i,
    output logic [2:0]     mode_o,
    output logic [AW-1:0]  cst_o,
    output logic [RIW-1:0] rf_raddr_o,
    output logic           mem_req_o,
    output logic [AW-1:0]  mem_addr_o,
    input  logic [DW-1:0]  mem_rdata_i,
    input  logic           mem_ready_i,
    output logic           busy_o,
    output logic           done_o,
    output logic           err_o,
    output logic [DW-1:0]  operand_o,
    output logic [AW-1:0]  ea_o,
    output logic           ea_valid_o
);
    typedef struct packed {
        opf_state_e     state;
        logic [2:0]     mode;
        logic [RIW-1:0] idx;
        logic [AW-1:0]  cst;
        logic [AW-1:0]  ea;
        logic           ea_valid;
        logic [DW-1:0]  operand;
        logic           err;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state    = ST_DECODE;
                    r_d.mode     = mode_i;
                    r_d.idx      = reg_idx_i;
                    r_d.cst      = const_i;
                    r_d.ea       = '0;
                    r_d.ea_valid = 1'b0;
                    r_d.operand  = '0;
                    r_d.err      = 1'b0;
                end
            end
            ST_DECODE: begin
                r_d.state = c_next_i;
                r_d.err   = c_err_i;
                if (c_ea_valid_i) begin
                    r_d.ea       = c_ea_i;
                    r_d.ea_valid = 1'b1;
                end
                if (c_operand_load_i) begin
                    r_d.operand = c_operand_i;
                end
            end
            ST_PTR: begin
                if (mem_ready_i) begin
                    r_d.ea       = AW'(mem_rdata_i);
                    r_d.ea_valid = 1'b1;
                    r_d.state    = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_ready_i) begin
                    r_d.operand = mem_rdata_i;
                    r_d.state   = ST_DONE;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, mode: '0, idx: '0, cst: '0, ea: '0,
                     ea_valid: 1'b0, operand: '0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mode_o     = r_q.mode;
    assign cst_o      = r_q.cst;
    assign rf_raddr_o = r_q.idx;
    assign mem_req_o  = (r_q.state == ST_PTR) || (r_q.state == ST_FETCH);
    assign mem_addr_o = (r_q.state == ST_PTR) ? r_q.cst : r_q.ea;
    assign busy_o     = (r_q.state != ST_IDLE);
    assign done_o     = (r_q.state == ST_DONE);
    assign err_o      = r_q.err;
    assign operand_o  = r_q.operand;
    assign ea_o       = r_q.ea;
    assign ea_valid_o = r_q.ea_valid;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)); // R10
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o); // R2
    AST_ERR_NO_EA: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && err_o |-> !ea_valid_o); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o && start_i |=> busy_o); // R9
endmodule

// File: rtl/opf_unit.sv
module opf_unit
    import opf_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 16,
    parameter int NREG = 16,
    localparam int RIW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [2:0]     mode_i,
    input  logic [RIW-1:0] reg_idx_i,
    input  logic [AW-1:0]  const_i,
    output logic [RIW-1:0] rf_raddr_o,
    input  logic [DW-1:0]  rf_rdata_i,
    output logic           mem_req_o,
    output logic [AW-1:0]  mem_addr_o,
    input  logic [DW-1:0]  mem_rdata_i,
    input  logic           mem_ready_i,
    output logic           busy_o,
    output logic           done_o,
    output logic           err_o,
    output logic [DW-1:0]  operand_o,
    output logic [AW-1:0]  ea_o,
    output logic           ea_valid_o
);
    logic [2:0]    lat_mode;
    logic [AW-1:0] lat_cst;
    opf_state_e    c_next;
    logic [AW-1:0] c_ea;
    logic          c_ea_valid;
    logic [DW-1:0] c_operand;
    logic          c_operand_load;
    logic          c_err;

    opf_ea_calc #(.AW(AW), .DW(DW)) u_calc (
        .mode_i         (lat_mode),
        .cst_i          (lat_cst),
        .rf_rdata_i     (rf_rdata_i),
        .next_o         (c_next),
        .ea_o           (c_ea),
        .ea_valid_o     (c_ea_valid),
        .operand_o      (c_operand),
        .operand_load_o (c_operand_load),
        .err_o          (c_err)
    );

    opf_seq #(.AW(AW), .DW(DW), .RIW(RIW)) u_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_i          (start_i),
        .mode_i           (mode_i),
        .reg_idx_i        (reg_idx_i),
        .const_i          (const_i),
        .c_next_i         (c_next),
        .c_ea_i           (c_ea),
        .c_ea_valid_i     (c_ea_valid),
        .c_operand_i      (c_operand),
        .c_operand_load_i (c_operand_load),
        .c_err_i          (c_err),
        .mode_o           (lat_mode),
        .cst_o            (lat_cst),
        .rf_raddr_o       (rf_raddr_o),
        .mem_req_o        (mem_req_o),
        .mem_addr_o       (mem_addr_o),
        .mem_rdata_i      (mem_rdata_i),
        .mem_ready_i      (mem_ready_i),
        .busy_o           (busy_o),
        .done_o           (done_o),
        .err_o            (err_o),
        .operand_o        (operand_o),
        .ea_o             (ea_o),
        .ea_valid_o       (ea_valid_o)
    );
endmodule

// File: tb/opf_unit_tb.sv
`timescale 1ns/1ps
module opf_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [3:0]  ridx = '0;
    logic [15:0] cst = '0;
    logic [3:0]  rf_raddr;
    logic [15:0] rf_rdata;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        mem_ready;
    logic        busy, done, err, ea_valid;
    logic [15:0] operand, ea;

    int n_cmp = 0;
    int n_bad = 0;
    int lat = 0;
    int wcnt = 0;
    int n_reads = 0;
    int cyc = 0;
    logic [15:0] prev_addr = '0;
    logic [15:0] last_addr = '0;

    always #2 clk = ~clk;

    opf_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .reg_idx_i(ridx), .const_i(cst), .rf_raddr_o(rf_raddr),
        .rf_rdata_i(rf_rdata), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready), .busy_o(busy),
        .done_o(done), .err_o(err), .operand_o(operand), .ea_o(ea),
        .ea_valid_o(ea_valid)
    );

    function automatic logic [15:0] regval(input logic [3:0] i);
        return 16'h1000 + 16'({12'd0, i}) * 16'h0101;
    endfunction
    function automatic logic [15:0] memval(input logic [15:0] a);
        return a * 16'd3 + 16'h1111;
    endfunction

    assign rf_rdata  = regval(rf_raddr);
    assign mem_rdata = memval(mem_addr);
    assign mem_ready = mem_req && (wcnt >= lat);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) begin
            if (wcnt >= lat) begin
                wcnt      <= 0;
                n_reads   <= n_reads + 1;
                prev_addr <= last_addr;
                last_addr <= mem_addr;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Issue one operation and wait for done; returns cycles from start to done.
    task automatic run_op(input logic [2:0] m, input logic [3:0] ri,
                          input logic [15:0] c, input int l, output int cycles,
                          output int reads);
        int r0;
        lat = l;
        @(negedge clk);
        r0 = n_reads;
        mode = m; ridx = ri; cst = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        while (!done && cycles < 60) begin
            @(negedge clk);
            cycles++;
        end
        if (!done) check("R10 done timeout", 0, 1);
        reads = n_reads - r0;
        @(negedge clk);
        check("R10 done one cycle", {31'd0, done}, 0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 busy", {31'd0, busy}, 0);
        check("R1 done", {31'd0, done}, 0);
        check("R1 err", {31'd0, err}, 0);
        check("R1 ea_valid", {31'd0, ea_valid}, 0);
        check("R1 mem_req", {31'd0, mem_req}, 0);
    endtask

    task automatic t_imm();
        int c, r;
        run_op(3'd0, 4'd3, 16'hBEEF, 0, c, r);
        check("R2 operand", {16'd0, operand}, 32'hBEEF);
        check("R2 ea_valid", {31'd0, ea_valid}, 0);
        check("R2 reads", r, 0);
        check("R2 latency", c, 2);
    endtask

    task automatic t_reg();
        int c, r;
        run_op(3'd1, 4'd7, 16'h0000, 0, c, r);
        check("R3 operand", {16'd0, operand}, {16'd0, regval(4'd7)});
        check("R3 ea_valid", {31'd0, ea_valid}, 0);
        check("R3 reads", r, 0);
    endtask

    task automatic t_abs();
        int c, r;
        run_op(3'd2, 4'd0, 16'h0420, 1, c, r);
        check("R4 ea", {16'd0, ea}, 32'h0420);
        check("R4 ea_valid", {31'd0, ea_valid}, 1);
        check("R4 operand", {16'd0, operand}, {16'd0, memval(16'h0420)});
        check("R4 reads", r, 1);
    endtask

    task automatic t_rind();
        int c, r;
        run_op(3'd3, 4'd2, 16'h5555, 0, c, r);
        check("R5 ea", {16'd0, ea}, {16'd0, regval(4'd2)});
        check("R5 operand", {16'd0, operand}, {16'd0, memval(regval(4'd2))});
        check("R5 reads", r, 1);
    endtask

    task automatic t_mind();
        int c, r;
        logic [15:0] ptr;
        ptr = memval(16'h0100);
        run_op(3'd4, 4'd9, 16'h0100, 2, c, r);
        check("R6 ea", {16'd0, ea}, {16'd0, ptr});
        check("R6 operand", {16'd0, operand}, {16'd0, memval(ptr)});
        check("R6 reads", r, 2);
        check("R6 first addr", {16'd0, prev_addr}, 32'h0100);
        check("R6 second addr", {16'd0, last_addr}, {16'd0, ptr});
        check("R6 latency", c, 8);
    endtask

    task automatic t_idx();
        int c, r;
        run_op(3'd5, 4'd15, 16'hF000, 0, c, r);
        check("R7 ea wrap", {16'd0, ea}, 32'h0F0F);
        check("R7 operand", {16'd0, operand}, {16'd0, memval(16'h0F0F)});
        run_op(3'd5, 4'd1, 16'h0010, 0, c, r);
        check("R7 ea", {16'd0, ea}, 32'h1111);
    endtask

    task automatic t_bad();
        int c, r;
        for (int m = 6; m < 8; m++) begin
            run_op(3'(m), 4'd4, 16'h0200, 0, c, r);
            check("R8 err", {31'd0, err}, 1);
            check("R8 ea_valid", {31'd0, ea_valid}, 0);
            check("R8 reads", r, 0);
        end
        run_op(3'd0, 4'd0, 16'h0001, 0, c, r);
        check("R8 err cleared", {31'd0, err}, 0);
    endtask

    task automatic t_busy_start();
        int dones;
        int r0;
        lat = 5;
        @(negedge clk);
        r0 = n_reads;
        mode = 3'd2; cst = 16'h0300; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        mode = 3'd0; cst = 16'h7777; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dones = 0;
        for (int i = 0; i < 20; i++) begin
            if (done) dones++;
            @(negedge clk);
        end
        check("R9 single done", dones, 1);
        check("R9 operand kept", {16'd0, operand}, {16'd0, memval(16'h0300)});
        check("R9 ea kept", {16'd0, ea}, 32'h0300);
        check("R9 reads", n_reads - r0, 1);
        check("R9 idle", {31'd0, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_imm();
        t_reg();
        t_abs();
        t_rind();
        t_mind();
        t_idx();
        t_bad();
        t_busy_start();
        finish_run();
    end

    initial begin
        #400000;
        check("watchdog", 0, 1);
        finish_run();
    end
endmodule